// File: doc/BRIEF.md
# Dual-Rail Register Stage with Completion Detection

This block is one pipeline register of a delay-insensitive, dual-rail datapath, written as a synchronous model. Each data bit travels on a true rail and a false rail. A word moves forward as a DATA wavefront, and every DATA wavefront is followed by an all-empty NULL wavefront before the next one may enter. The following stage steers the register through a single request line. While the request is high the register takes in DATA. While it is low the register takes in NULL. In every other case each rail keeps its value.

Each bit reports whether it is empty. A completion tree combines these per-bit flags into one acknowledge for the preceding stage. The acknowledge drops only once the whole word holds DATA, and rises only once the whole word is empty. For any mix of DATA and NULL bits it keeps its previous value. Chaining stages connects each stage's acknowledge to the request input of the stage before it. This keeps successive tokens apart. A parameter gives each bit its reset code: NULL, DATA0 or DATA1.

Top module: `dr_reg_stage`

## Requirements
- R1: Bit i is carried on `dout_t[i]` (true rail) and `dout_f[i]` (false rail). The encodings are 00 for NULL, `t=1,f=0` for DATA1 and `t=0,f=1` for DATA0. The inputs `din_t`/`din_f` use the same encoding.
- R2: A rail output becomes 1 on the clock edge after its rail input and `nxt_req` are both high.
- R3: A rail output becomes 0 on the clock edge after its rail input and `nxt_req` are both low.
- R4: When a rail input and `nxt_req` differ, the rail output holds its value. DATA that arrives while `nxt_req` is low is ignored, and NULL that arrives while `nxt_req` is high is ignored.
- R5: `prv_ack` is 0 on the edge after every output bit holds DATA.
- R6: `prv_ack` is 1 on the edge after every output bit holds NULL. It holds its value while the outputs are a mix of DATA and NULL.
- R7: A synchronous reset loads each bit with its reset code. Bit i is NULL when `RST_DATA_MASK[i]` is 0, and otherwise DATA1 or DATA0 as `RST_DATA_VAL[i]` is 1 or 0. `prv_ack` resets to 0 only when every bit resets to DATA, and to 1 otherwise.
- R8: If the inputs change between DATA and NULL only through the NULL code, no output bit ever shows 11.
- R9: Two stages chained through a dual-rail connection deliver every DATA token in the order it was offered, with an all-NULL word between any two tokens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nxt_req | input | 1 | Request from the following stage: 1 asks for DATA, 0 asks for NULL |
| din_t | input | WIDTH | True rails of the incoming word |
| din_f | input | WIDTH | False rails of the incoming word |
| dout_t | output | WIDTH | True rails of the stored word |
| dout_f | output | WIDTH | False rails of the stored word |
| prv_ack | output | 1 | Acknowledge to the preceding stage: 1 when the word is all NULL, 0 when it is all DATA |

## Verification
The bench builds three copies of the stage:
- Two 8-bit stages with NULL reset are chained. A bench model tracks them on every clock while random producer and consumer stalls stress the four-phase handshake.
- A 3-bit stage resets to a mix of DATA1, DATA0 and NULL. Its width is not a power of two, so the completion tree must pad unused leaves. Its mixed reset lets the bench hold a partly complete word and watch the acknowledge hold.
- A 4-bit stage resets every bit to DATA. This covers the reset case where the acknowledge starts low.

// File: rtl/dr_pkg.sv
package dr_pkg;

    typedef struct packed {
        logic t;
        logic f;
    } drail_t;

    // One rail of a two-input hysteresis gate: sets when both inputs are high,
    // clears when both are low, otherwise keeps its state.
    function automatic logic hyst2(input logic a, input logic b, input logic q);
        if (a && b)
            return 1'b1;
        if (!a && !b)
            return 1'b0;
        return q;
    endfunction

    function automatic drail_t rst_code(input logic is_data, input logic val);
        drail_t c;
        c.t = is_data & val;
        c.f = is_data & ~val;
        return c;
    endfunction

endpackage

// File: rtl/dr_bit_cell.sv
module dr_bit_cell
    import dr_pkg::*;
#(
    parameter logic RST_IS_DATA = 1'b0,
    parameter logic RST_VAL     = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req,
    input  drail_t d,
    output drail_t q,
    output logic   empty
);
    localparam drail_t RST_Q = rst_code(RST_IS_DATA, RST_VAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_Q;
        end else begin
            q.t <= hyst2(d.t, req, q.t);
            q.f <= hyst2(d.f, req, q.f);
        end
    end

    // Empty flag: high when neither rail is set.
    assign empty = ~(q.t | q.f);

endmodule

// File: rtl/dr_cmpl_tree.sv
module dr_cmpl_tree #(
    parameter int   N      = 8,
    parameter logic RST_KO = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] empty,
    output logic         ack
);
    localparam int LVL = (N > 1) ? $clog2(N) : 0;
    localparam int P   = 1 << LVL;

    // Heap-indexed reduction: node k combines children 2k and 2k+1.
    logic [2*P-1:1] all_null;
    logic [2*P-1:1] all_data;

    for (genvar i = 0; i < P; i++) begin : g_leaf
        if (i < N) begin : g_real
            assign all_null[P+i] = empty[i];
            assign all_data[P+i] = ~empty[i];
        end else begin : g_pad
            assign all_null[P+i] = 1'b1;
            assign all_data[P+i] = 1'b1;
        end
    end

    for (genvar k = 1; k < P; k++) begin : g_node
        assign all_null[k] = all_null[2*k] & all_null[2*k+1];
        assign all_data[k] = all_data[2*k] & all_data[2*k+1];
    end

    always_ff @(posedge clk) begin
        if (rst)
            ack <= RST_KO;
        else if (all_null[1])
            ack <= 1'b1;
        else if (all_data[1])
            ack <= 1'b0;
    end

endmodule

// File: rtl/dr_reg_stage.sv
module dr_reg_stage
    import dr_pkg::*;
#(
    parameter int               WIDTH         = 8,
    parameter logic [WIDTH-1:0] RST_DATA_MASK = '0,
    parameter logic [WIDTH-1:0] RST_DATA_VAL  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nxt_req,
    input  logic [WIDTH-1:0] din_t,
    input  logic [WIDTH-1:0] din_f,
    output logic [WIDTH-1:0] dout_t,
    output logic [WIDTH-1:0] dout_f,
    output logic             prv_ack
);
    // Acknowledge starts low only when the whole word resets to DATA.
    localparam logic KO_RST = ~(&RST_DATA_MASK);

    logic [WIDTH-1:0] bit_empty;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        drail_t d_i;
        drail_t q_i;

        assign d_i = '{t: din_t[i], f: din_f[i]};

        dr_bit_cell #(
            .RST_IS_DATA(RST_DATA_MASK[i]),
            .RST_VAL    (RST_DATA_VAL[i])
        ) u_cell (
            .clk  (clk),
            .rst  (rst),
            .req  (nxt_req),
            .d    (d_i),
            .q    (q_i),
            .empty(bit_empty[i])
        );

        assign dout_t[i] = q_i.t;
        assign dout_f[i] = q_i.f;
    end

    dr_cmpl_tree #(
        .N     (WIDTH),
        .RST_KO(KO_RST)
    ) u_tree (
        .clk  (clk),
        .rst  (rst),
        .empty(bit_empty),
        .ack  (prv_ack)
    );

endmodule

// File: rtl/dr_reg_stage_chk.sv
module dr_reg_stage_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             nxt_req,
    input logic [WIDTH-1:0] din_t,
    input logic [WIDTH-1:0] din_f,
    input logic [WIDTH-1:0] dout_t,
    input logic [WIDTH-1:0] dout_f,
    input logic             prv_ack
);
    logic word_data;
    logic word_null;

    assign word_data = &(dout_t ^ dout_f);
    assign word_null = ~|(dout_t | dout_f);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // R2
        a_r2_set_t: assert property (@(posedge clk) disable iff (rst)
            (nxt_req && din_t[i]) |=> dout_t[i]);
        a_r2_set_f: assert property (@(posedge clk) disable iff (rst)
            (nxt_req && din_f[i]) |=> dout_f[i]);
        // R3
        a_r3_clr_t: assert property (@(posedge clk) disable iff (rst)
            (!nxt_req && !din_t[i]) |=> !dout_t[i]);
        a_r3_clr_f: assert property (@(posedge clk) disable iff (rst)
            (!nxt_req && !din_f[i]) |=> !dout_f[i]);
        // R4
        a_r4_hold_t: assert property (@(posedge clk) disable iff (rst)
            (nxt_req != din_t[i]) |=> $stable(dout_t[i]));
        a_r4_hold_f: assert property (@(posedge clk) disable iff (rst)
            (nxt_req != din_f[i]) |=> $stable(dout_f[i]));
        // R8
        a_r8_no_illegal: assert property (@(posedge clk) disable iff (rst)
            $onehot0({dout_t[i], dout_f[i]}));
    end

    // R5
    a_r5_ack_low: assert property (@(posedge clk) disable iff (rst)
        word_data |=> !prv_ack);
    // R6
    a_r6_ack_high: assert property (@(posedge clk) disable iff (rst)
        word_null |=> prv_ack);
    a_r6_ack_hold: assert property (@(posedge clk) disable iff (rst)
        (!word_data && !word_null) |=> $stable(prv_ack));

endmodule

bind dr_reg_stage dr_reg_stage_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .nxt_req(nxt_req),
    .din_t  (din_t),
    .din_f  (din_f),
    .dout_t (dout_t),
    .dout_f (dout_f),
    .prv_ack(prv_ack)
);

// File: tb/tb_dr_reg_stage.sv
module tb_dr_reg_stage;
    localparam int W     = 8;
    localparam int NTOK  = 150;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    // Chain: dut (upstream) -> dut_b (downstream)
    logic [W-1:0] a_in_t = '0, a_in_f = '0;
    logic [W-1:0] a_out_t, a_out_f, b_out_t, b_out_f;
    logic         ko_a, ko_b;
    logic         ki_b = 1'b0;

    dr_reg_stage #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .nxt_req(ko_b),
        .din_t(a_in_t), .din_f(a_in_f),
        .dout_t(a_out_t), .dout_f(a_out_f), .prv_ack(ko_a));

    dr_reg_stage #(.WIDTH(W)) dut_b (
        .clk(clk), .rst(rst), .nxt_req(ki_b),
        .din_t(a_out_t), .din_f(a_out_f),
        .dout_t(b_out_t), .dout_f(b_out_f), .prv_ack(ko_b));

    // Mixed reset: bit0 DATA1, bit1 DATA0, bit2 NULL
    logic       ki_m = 1'b1;
    logic [2:0] m_in_t = '0, m_in_f = '0, m_out_t, m_out_f;
    logic       ko_m;
    dr_reg_stage #(.WIDTH(3), .RST_DATA_MASK(3'b011), .RST_DATA_VAL(3'b001)) dut_m (
        .clk(clk), .rst(rst), .nxt_req(ki_m),
        .din_t(m_in_t), .din_f(m_in_f),
        .dout_t(m_out_t), .dout_f(m_out_f), .prv_ack(ko_m));

    // All-DATA reset: value 4'hA
    logic [3:0] d_out_t, d_out_f;
    logic       ko_d;
    dr_reg_stage #(.WIDTH(4), .RST_DATA_MASK(4'hF), .RST_DATA_VAL(4'hA)) dut_d (
        .clk(clk), .rst(rst), .nxt_req(1'b1),
        .din_t(4'h0), .din_f(4'h0),
        .dout_t(d_out_t), .dout_f(d_out_f), .prv_ack(ko_d));

    // Behavioural reference for the chain
    logic [W-1:0] mAt, mAf, mBt, mBf;
    logic         mAko, mBko;

    function automatic logic rail(input logic x, input logic req, input logic q);
        if (req && x)   return 1'b1;
        if (!req && !x) return 1'b0;
        return q;
    endfunction

    function automatic logic ack_step(input logic [W-1:0] t, input logic [W-1:0] f, input logic k);
        int nd = 0;
        int nn = 0;
        for (int i = 0; i < W; i++) begin
            if (t[i] != f[i]) nd++;
            if (!t[i] && !f[i]) nn++;
        end
        if (nn == W) return 1'b1;
        if (nd == W) return 1'b0;
        return k;
    endfunction

    always @(posedge clk) begin
        logic [W-1:0] nAt, nAf, nBt, nBf;
        logic nAk, nBk;
        if (rst) begin
            mAt = '0; mAf = '0; mBt = '0; mBf = '0; mAko = 1'b1; mBko = 1'b1;
        end else begin
            for (int i = 0; i < W; i++) begin
                nAt[i] = rail(a_in_t[i], mBko, mAt[i]);
                nAf[i] = rail(a_in_f[i], mBko, mAf[i]);
                nBt[i] = rail(mAt[i], ki_b, mBt[i]);
                nBf[i] = rail(mAf[i], ki_b, mBf[i]);
            end
            nAk = ack_step(mAt, mAf, mAko);
            nBk = ack_step(mBt, mBf, mBko);
            mAt = nAt; mAf = nAf; mBt = nBt; mBf = nBf; mAko = nAk; mBko = nBk;
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit timed_out = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
        cyc++;
        if (cyc > LIMIT) timed_out = 1;
        if (!rst) begin
            check({a_out_t, a_out_f, ko_a} === {mAt, mAf, mAko},
                  "R2/R3/R4/R5/R6 model stage A", {a_out_t, a_out_f, ko_a}, {mAt, mAf, mAko});
            check({b_out_t, b_out_f, ko_b} === {mBt, mBf, mBko},
                  "R2/R3/R4/R5/R6 model stage B", {b_out_t, b_out_f, ko_b}, {mBt, mBf, mBko});
        end
    endtask

    logic [W-1:0] exp_q[$];
    logic [W-1:0] v, last_tok, exp_v;
    int  sent = 0, rcv = 0;
    bit  p_data = 0, null_since = 1;
    bit  bdata, bnull;

    initial begin
        repeat (3) tick;
        rst = 1'b0;
        // R7: reset values
        check({a_out_t, a_out_f, ko_a} == {16'h0, 1'b1}, "R7 chain reset NULL", {a_out_t, a_out_f, ko_a}, {16'h0, 1'b1});
        check({m_out_t, m_out_f, ko_m} == {3'b001, 3'b010, 1'b1}, "R7 mixed reset", {m_out_t, m_out_f, ko_m}, {3'b001, 3'b010, 1'b1});
        check({d_out_t, d_out_f, ko_d} == {4'hA, 4'h5, 1'b0}, "R7 all-DATA reset", {d_out_t, d_out_f, ko_d}, {4'hA, 4'h5, 1'b0});
        tick;
        check({m_out_t, m_out_f, ko_m} == {3'b001, 3'b010, 1'b1}, "R4 mixed state held", {m_out_t, m_out_f, ko_m}, {3'b001, 3'b010, 1'b1});
        check({d_out_t, d_out_f, ko_d} == {4'hA, 4'h5, 1'b0}, "R4 DATA state held", {d_out_t, d_out_f, ko_d}, {4'hA, 4'h5, 1'b0});

        // Token 0xA5 into stage A; downstream stalled
        a_in_t = 8'hA5; a_in_f = 8'h5A;
        tick;
        check({a_out_t, a_out_f} == {8'hA5, 8'h5A}, "R1 R2 DATA captured", {a_out_t, a_out_f}, {8'hA5, 8'h5A});
        tick;
        check(ko_a == 1'b0, "R5 ack low on full DATA", ko_a, 0);
        tick; tick;
        check({b_out_t, b_out_f, ko_b} == {16'h0, 1'b1}, "R4 DATA ignored with request low", {b_out_t, b_out_f, ko_b}, {16'h0, 1'b1});
        a_in_t = '0; a_in_f = '0;
        tick; tick;
        check({a_out_t, a_out_f, ko_a} == {8'hA5, 8'h5A, 1'b0}, "R4 NULL ignored with request high", {a_out_t, a_out_f, ko_a}, {8'hA5, 8'h5A, 1'b0});
        ki_b = 1'b1;
        tick;
        check({b_out_t, b_out_f} == {8'hA5, 8'h5A}, "R2 downstream capture", {b_out_t, b_out_f}, {8'hA5, 8'h5A});
        tick;
        check(ko_b == 1'b0, "R5 downstream ack low", ko_b, 0);
        tick;
        check({a_out_t, a_out_f} == 16'h0, "R3 upstream cleared", {a_out_t, a_out_f}, 0);
        tick;
        check(ko_a == 1'b1, "R6 upstream ack high", ko_a, 1);
        check({b_out_t, b_out_f} == {8'hA5, 8'h5A}, "R4 downstream holds DATA", {b_out_t, b_out_f}, {8'hA5, 8'h5A});
        ki_b = 1'b0;
        tick;
        check({b_out_t, b_out_f} == 16'h0, "R3 downstream cleared", {b_out_t, b_out_f}, 0);
        tick;
        check(ko_b == 1'b1, "R6 downstream ack high", ko_b, 1);

        // Mixed stage: complete the word, then leave it partly NULL
        m_in_t = 3'b100;
        tick;
        check({m_out_t, m_out_f} == {3'b101, 3'b010}, "R2 mixed completes", {m_out_t, m_out_f}, {3'b101, 3'b010});
        tick;
        check(ko_m == 1'b0, "R5 mixed ack low", ko_m, 0);
        ki_m = 1'b0;
        tick;
        check({m_out_t, m_out_f} == {3'b100, 3'b000}, "R3 partial clear", {m_out_t, m_out_f}, {3'b100, 3'b000});
        tick;
        check(ko_m == 1'b0, "R6 ack holds on partial word", ko_m, 0);
        tick;
        check(ko_m == 1'b0, "R6 ack still held", ko_m, 0);
        m_in_t = 3'b000;
        tick;
        check({m_out_t, m_out_f} == 6'h0, "R3 mixed empty", {m_out_t, m_out_f}, 0);
        tick;
        check(ko_m == 1'b1, "R6 mixed ack high", ko_m, 1);

        // Random four-phase traffic through the chain
        while (rcv < NTOK && !timed_out) begin
            tick;
            if (!p_data && ko_a && sent < NTOK && ($urandom % 4) != 0) begin
                v = W'($urandom);
                a_in_t = v; a_in_f = ~v;
                exp_q.push_back(v);
                sent++; p_data = 1;
            end else if (p_data && !ko_a && ($urandom % 4) != 0) begin
                a_in_t = '0; a_in_f = '0; p_data = 0;
            end
            bdata = &(b_out_t ^ b_out_f);
            bnull = ~|(b_out_t | b_out_f);
            check(~|(b_out_t & b_out_f), "R8 no 11 code", b_out_t & b_out_f, 0);
            if (bnull) null_since = 1;
            if (bdata && !null_since && b_out_t != last_tok)
                check(0, "R9 token without NULL separation", b_out_t, last_tok);
            if (ki_b && bdata && ($urandom % 3) != 0) begin
                exp_v = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
                check(null_since && b_out_t == exp_v, "R9 token order", b_out_t, exp_v);
                last_tok = b_out_t; null_since = 0; ki_b = 1'b0; rcv++;
            end else if (!ki_b && bnull && ($urandom % 3) != 0) begin
                ki_b = 1'b1;
            end
        end
        if (timed_out)
            check(0, "R9 watchdog expired", rcv, NTOK);
        else
            check(exp_q.size() == 0, "R9 all tokens delivered", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule